// File: doc/BRIEF.md
# Serial-Fold Pipelined Accumulator

This block sums a stream of integer operands, one per clock, into a single total per vector, as the final stage of a dot-product unit. Its adder is deliberately retimed into a fixed number of register stages, K, so it can run at a high clock rate. Each arriving operand enters one adder port, and the adder's own output returns to the other port. The K pipeline registers therefore carry K independent partial sums that rotate through the adder. No operand is ever stalled while a vector streams in.

When the beat flagged as the end of the vector has been taken, the block stops accepting input. It moves K−1 of the partial sums into a small shift buffer. It then reuses the same adder to fold the buffer entries one at a time into the remaining partial sum. Each fold waits the full K-cycle adder latency, so the reduction costs K(K−1) cycles. The total is then offered on a valid/ready output and held until it is taken. After that, the pipeline is cleared for the next vector.

Top module: `serial_fold_acc`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: While a vector is streaming, in_ready stays 1 and a beat is accepted on every clock edge where in_valid is 1, so a vector of any length enters without stalls.
- R3: out_data equals the sum of the in_data values of all beats accepted in the vector, including the beat with in_last set.
- R4: Clock edges with in_valid at 0 between beats of a vector do not change the result.
- R5: The result is correct for vectors shorter than K (a single beat included), equal to K, and longer than K; pipeline slots that received no beat contribute zero.
- R6: in_ready is 0 from the cycle after the in_last beat is accepted until out_valid and out_ready are both 1 at a clock edge, and is 1 again in the cycle after that edge.
- R7: out_valid rises exactly K·K−1 clock edges after the edge that accepts the in_last beat: K−1 edges of drain and K(K−1) edges of serial fold.
- R8: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data does not change.
- R9: Exactly one result is produced per vector: out_valid falls in the cycle after the edge where out_valid and out_ready are both 1.
- R10: Sums wrap modulo 2^W (for example, 0xFFFFFFF0 plus 0x20 gives 0x10 at W = 32).
- R11: Beats presented with in_valid at 1 while in_ready is 0 are ignored and change neither the pending result nor the next vector's result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand beat present |
| in_ready | output | 1 | Block can take an operand beat |
| in_data | input | W | Operand value |
| in_last | input | 1 | Marks the final beat of a vector |
| out_valid | output | 1 | Vector total available |
| out_ready | input | 1 | Downstream takes the total |
| out_data | output | W | Vector total, modulo 2^W |

## Verification
The embedded properties check the handshake discipline on every cycle. They confirm that input is refused from the last beat until the total is taken, and that input reopens right after. They confirm that a pending total stays stable under back-pressure and that it disappears once accepted. Only the bench scenarios can show that the totals are arithmetically right. Those scenarios cover vectors shorter and longer than K, idle gaps, wrap-around and beats offered while busy. They also measure the exact K·K−1 edge distance from the last beat to the total.

// File: rtl/serial_fold_acc.sv
module serial_fold_acc #(
  parameter int W = 32,
  parameter int K = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         in_last,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  localparam int CW = $clog2(K) + 1;

  typedef enum logic [1:0] {ACC, DRAIN, FOLD, DONE} state_t;

  state_t         state;
  logic [W-1:0]   pipe [K];
  logic [W-1:0]   sbuf [K-1];
  logic [CW-1:0]  ph;
  logic [CW-1:0]  nfold;
  logic [W-1:0]   add_a, add_b;
  logic           take, issue;

  assign in_ready  = (state == ACC);
  assign out_valid = (state == DONE);
  assign out_data  = pipe[K-1];
  assign take      = in_valid && in_ready;
  assign issue     = (state == FOLD) && (ph == '0) && (nfold < CW'(K-1));

  always_comb begin
    add_a = '0;
    add_b = '0;
    case (state)
      ACC: begin
        add_a = take ? in_data : '0;
        add_b = pipe[K-1];
      end
      FOLD: if (issue) begin
        add_a = sbuf[0];
        add_b = pipe[K-1];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < K; i++) pipe[i] <= '0;
    end else if (state == DONE) begin
      if (out_ready)
        for (int i = 0; i < K; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= add_a + add_b;
      for (int i = 1; i < K; i++) pipe[i] <= pipe[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < K-1; i++) sbuf[i] <= '0;
    end else if (state == DRAIN || issue) begin
      for (int i = 0; i < K-2; i++) sbuf[i] <= sbuf[i+1];
      sbuf[K-2] <= (state == DRAIN) ? pipe[K-1] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ACC;
      ph    <= '0;
      nfold <= '0;
    end else begin
      case (state)
        ACC: if (take && in_last) begin
          state <= DRAIN;
          ph    <= '0;
        end
        DRAIN: begin
          if (ph == CW'(K-2)) begin
            state <= FOLD;
            ph    <= '0;
            nfold <= '0;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        FOLD: begin
          if (issue) nfold <= nfold + 1'b1;
          if (ph == CW'(K-1)) begin
            ph <= '0;
            if (nfold == CW'(K-1)) state <= DONE;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        DONE: if (out_ready) state <= ACC;
        default: state <= ACC;
      endcase
    end
  end

  p_closed_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> !in_ready);

  p_closed_while_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_reopen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> in_ready);

  p_hold_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_single_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !out_valid);

  p_no_early_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> !out_valid);

endmodule

// File: tb/serial_fold_acc_tb.sv
`timescale 1ns/1ps
module serial_fold_acc_tb;
  localparam int W = 32;
  localparam int K = 4;
  localparam int NV = 7;

  localparam int T_LEN  [NV] = '{1, 3, 4, 5, 11, 8, 17};
  localparam int T_BASE [NV] = '{7, 10, 1, 100, 2, 1000, 0};
  localparam int T_STEP [NV] = '{0, 5, 1, 3, 7, 0, 1};
  localparam int T_GAP  [NV] = '{0, 0, 0, 1, 0, 1, 1};
  localparam int T_JUNK [NV] = '{0, 1, 0, 0, 1, 0, 1};
  localparam int T_EXP  [NV] = '{7, 45, 10, 530, 407, 8000, 136};

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_last = 0, out_ready = 0;
  logic [W-1:0] in_data = '0;
  logic in_ready, out_valid;
  logic [W-1:0] out_data;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  serial_fold_acc #(.W(W), .K(K)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic beat(input logic [W-1:0] d, input logic last);
    chk(in_ready == 1'b1, "R2 ready during stream", in_ready, 1);
    in_valid = 1; in_data = d; in_last = last;
    @(posedge clk); @(negedge clk);
    in_valid = 0; in_last = 0; in_data = '0;
  endtask

  task automatic finish_vector(input logic [W-1:0] exp, input bit junk, input string req);
    int n = 0;
    bit busy_ok = 1;
    while (!out_valid && n < 100) begin
      if (in_ready) busy_ok = 0;
      if (junk) begin in_valid = 1; in_data = 32'h5555; in_last = 1; end
      @(posedge clk); n++; @(negedge clk);
    end
    in_valid = 0; in_last = 0; in_data = '0;
    chk(busy_ok, "R6 in_ready low while reducing", busy_ok, 1);
    chk(n == K*K-1, "R7 latency edges", n, K*K-1);
    chk(out_data == exp, req, out_data, exp);
    repeat (3) begin @(posedge clk); @(negedge clk); end
    chk(out_valid && out_data == exp, "R8 held under back-pressure", out_data, exp);
    chk(!in_ready, "R6 closed while result pending", in_ready, 0);
    out_ready = 1;
    @(posedge clk); @(negedge clk);
    out_ready = 0;
    chk(!out_valid, "R9 single result", out_valid, 0);
    chk(in_ready, "R6 reopened after accept", in_ready, 1);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready == 1, "R1 reset in_ready", in_ready, 1);
    chk(out_valid == 0, "R1 reset out_valid", out_valid, 0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < T_LEN[v]; i++) begin
        if (T_GAP[v] != 0 && (i % 2) == 1) begin @(posedge clk); @(negedge clk); end
        beat(W'(T_BASE[v] + i * T_STEP[v]), i == T_LEN[v] - 1);
      end
      finish_vector(W'(T_EXP[v]), T_JUNK[v] != 0, "R3 R4 R5 R11 vector sum");
    end

    beat(32'hFFFF_FFF0, 0);
    beat(32'h0000_0020, 1);
    finish_vector(32'h10, 0, "R10 wrap-around sum");

    beat(32'd9, 1);
    finish_vector(32'd9, 1, "R5 single beat after junk R11");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule